// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

This block chooses the one interrupt request that is shown to the processor at any moment. Every source has a pending flag, an enable bit and a priority. The priority is not stored per source. Each source carries a small index that selects one entry of a shared table of 4-bit priorities, so several sources can share a priority setting.

Only one request is outstanding at a time, and it is held in a register until the processor acknowledges it. While the register is empty, a newly raised enabled source is taken at once. When several sources arrive in the same cycle, the lowest source number wins and priority plays no part. On an acknowledge the served request is released. In the same cycle the block scans every pending source through a combinational maximum tree and takes the winner as the next request. One programmable source number can be steered to a separate fast-interrupt output in place of the normal one. Sources named in a parameter mask are level sensitive. Their pending flag follows the input, and their outstanding request is withdrawn when the input falls.

The source signals reach the block already conditioned. Level sources hold their input high while they want service. Pulse sources raise their input for one cycle per event. Configuration is write-only, through a select/address/data port. A write takes effect from the next cycle.

Top module: `pia_arbiter`

## Requirements
- R1: After reset both outputs are invalid with zero codes, all enable bits and priority table entries are zero, all index map entries select table entry 0, the fast selector is off, and no pending flag is set.
- R2: Configuration select 0 writes enable byte `cfgAddr` from `cfgData[7:0]`. Source n is enabled by bit (n mod 8) of byte n/8. A raised source that is disabled is never latched on arrival, but its pending flag is still set.
- R3: Source 0 is never presented on either output, whether it arrives or wins a rescan.
- R4: While no request is outstanding, the lowest-numbered enabled source (number 1 or above) whose input is high in a cycle is latched at that clock edge. Its priority plays no part in this choice. While a request is outstanding, arrivals only set pending flags.
- R5: The output code carries the priority in bits 11:8 and the source number in bits 7:0. The priority is read as table entry `map[n]` at the moment of latching. Select 1 writes table entry `cfgAddr` from `cfgData[3:0]`. Select 2 writes the map entry of source `cfgAddr` from `cfgData[3:0]`.
- R6: Select 3 writes the fast selector: bit 15 is the enable and bits 7:0 are the vector. A request whose source equals the vector while the enable is set appears on the fast output instead of the normal output. An output that carries no request shows valid 0 and code 0, and the two outputs are never valid together.
- R7: An outstanding request and its code hold until the processor acknowledges it, or until the source is a level source and its input falls.
- R8: An acknowledge releases the outstanding request. It clears the pending flag of a pulse source unless that source raises again in the same cycle. A level source's flag keeps following its input.
- R9: On acknowledge, pending sources are scanned in ascending order, and a source replaces the current best only if its priority is strictly greater. Ties therefore go to the lower number, and a priority of 0 never wins.
- R10: The rescan winner becomes the new outstanding request only if it is enabled and is not source 0. Otherwise no request is outstanding after the acknowledge.
- R11: When the outstanding request belongs to a level source whose input is low, and no acknowledge arrives, the request is dropped at that edge. A new arrival can be latched at the same edge.
- R12: An acknowledge while no request is outstanding changes nothing except the normal pending and arrival handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| srcReq | input | NUM_SRC | Per-source request inputs (pulse or level, per LEVEL_MASK) |
| ackIn | input | 1 | Processor acknowledge of the outstanding request |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Target: 0 enable byte, 1 priority entry, 2 index map, 3 fast selector |
| cfgAddr | input | 8 | Byte, entry or source number of the write |
| cfgData | input | 16 | Write data |
| irqValid | output | 1 | Normal request present |
| irqCode | output | 12 | Normal request priority and source |
| fiqValid | output | 1 | Fast request present |
| fiqCode | output | 12 | Fast request priority and source |

## Verification
Directed sequences first exercise arrivals on a block that was just reset. This shows that pending flags are separate from enables. Simultaneous arrivals with different priorities show that arrival order, not priority, picks the first request. Rescans are then driven over pending sets that contain ties, zero-priority entries, a disabled winner and source 0, to separate strict from non-strict comparison and to show the enable gate on the winner. Level sources are raised and dropped while they are outstanding, with and without an acknowledge in the same cycle. The fast vector is moved between sources, which tells routing apart from selection. A long random phase then mixes pulses, level changes, acknowledges and configuration rewrites, so that the latch-time priority lookup is caught against later table changes.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int SRC_W  = 8;
  localparam int PRIO_W = 4;
  localparam int CODE_W = PRIO_W + SRC_W;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_PRIO   = 2'd1,
    CFG_MAP    = 2'd2,
    CFG_FAST   = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic serve;
    logic loadScan;
    logic loadNew;
    logic clear;
  } ctlStrobe_t;
endpackage

// File: rtl/pia_maxtree.sv
module pia_maxtree #(
  parameter int N      = 32,
  parameter int PRIO_W = 4,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0][PRIO_W-1:0] leafPrio,
  output logic [SEL_W-1:0]         bestIdx,
  output logic [PRIO_W-1:0]        bestPrio
);
  // heap layout: node k has children 2k (lower numbers) and 2k+1
  logic [PRIO_W-1:0] nodePrio [1:2*N-1];
  logic [SEL_W-1:0]  nodeIdx  [1:2*N-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign nodePrio[N+i] = leafPrio[i];
    assign nodeIdx[N+i]  = SEL_W'(i);
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    logic pickRight;
    // strict compare keeps the lower-numbered side on a tie
    assign pickRight   = nodePrio[2*k+1] > nodePrio[2*k];
    assign nodePrio[k] = pickRight ? nodePrio[2*k+1] : nodePrio[2*k];
    assign nodeIdx[k]  = pickRight ? nodeIdx[2*k+1]  : nodeIdx[2*k];
  end

  assign bestIdx  = nodeIdx[1];
  assign bestPrio = nodePrio[1];
endmodule

// File: rtl/pia_control.sv
module pia_control
  import pia_pkg::*;
(
  input  logic       ackIn,
  input  logic       reqValid,
  input  logic       reqLevel,
  input  logic       reqInHigh,
  input  logic       scanHit,
  input  logic       newHit,
  output ctlStrobe_t strobe
);
  logic dropReq;
  logic latchFree;

  always_comb begin
    strobe.serve    = ackIn & reqValid;
    dropReq         = reqValid & ~strobe.serve & reqLevel & ~reqInHigh;
    latchFree       = ~reqValid | dropReq;
    strobe.loadScan = strobe.serve & scanHit;
    strobe.loadNew  = ~strobe.serve & latchFree & newHit;
    strobe.clear    = (strobe.serve & ~scanHit) | (dropReq & ~newHit);
  end
endmodule

// File: rtl/pia_datapath.sv
module pia_datapath
  import pia_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PTAB = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int SEL_W    = $clog2(NUM_SRC),
  localparam int IDX_W    = $clog2(NUM_PTAB),
  localparam int EN_BYTES = NUM_SRC / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [7:0]         cfgAddr,
  input  logic [15:0]        cfgData,
  input  ctlStrobe_t         strobe,
  output logic               reqValid,
  output logic               reqLevel,
  output logic               reqInHigh,
  output logic               scanHit,
  output logic               newHit,
  output logic [SRC_W-1:0]   reqSrcOut,
  output logic [PRIO_W-1:0]  reqPrioOut,
  output logic               reqFast
);
  logic [7:0]        enByte  [EN_BYTES];
  logic [PRIO_W-1:0] prioTab [NUM_PTAB];
  logic [IDX_W-1:0]  idxMap  [NUM_SRC];
  logic              fastOn;
  logic [SRC_W-1:0]  fastVec;

  logic [NUM_SRC-1:0] pendQ;
  logic [SEL_W-1:0]   reqSrcQ;
  logic [PRIO_W-1:0]  reqPrioQ;
  logic               reqValidQ;
  logic               reqFastQ;

  logic [NUM_SRC-1:0]             enVec;
  logic [NUM_SRC-1:0][PRIO_W-1:0] srcPrio;
  logic [NUM_SRC-1:0][PRIO_W-1:0] scanPrio;
  logic [NUM_SRC-1:0]             servedMask;
  logic [NUM_SRC-1:0]             pendAfterServe;
  logic [NUM_SRC-1:0]             pendAfterHold;
  logic [NUM_SRC-1:0]             arrive;
  logic [SEL_W-1:0]               bestIdx;
  logic [PRIO_W-1:0]              bestPrio;
  logic [SEL_W-1:0]               newIdx;
  logic                           unusedBits;

  assign unusedBits = ^cfgData[14:8];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign enVec[n]      = enByte[n/8][n%8];
    assign srcPrio[n]    = prioTab[idxMap[n]];
    assign servedMask[n] = reqValidQ && !LEVEL_MASK[n] && (reqSrcQ == SEL_W'(n));
    assign scanPrio[n]   = pendAfterServe[n] ? srcPrio[n] : '0;
  end

  // level sources mirror the input; pulse sources accumulate until served
  assign pendAfterServe = (LEVEL_MASK & srcReq) | (~LEVEL_MASK & ((pendQ & ~servedMask) | srcReq));
  assign pendAfterHold  = (LEVEL_MASK & srcReq) | (~LEVEL_MASK & (pendQ | srcReq));

  pia_maxtree #(.N(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
    .leafPrio(scanPrio),
    .bestIdx (bestIdx),
    .bestPrio(bestPrio)
  );

  assign scanHit = (bestPrio != '0) && (bestIdx != '0) && enVec[bestIdx];
  assign arrive  = srcReq & enVec & ~NUM_SRC'(1);

  always_comb begin
    newHit = 1'b0;
    newIdx = '0;
    for (int n = NUM_SRC - 1; n >= 1; n--) begin
      if (arrive[n]) begin
        newHit = 1'b1;
        newIdx = SEL_W'(n);
      end
    end
  end

  assign reqValid  = reqValidQ;
  assign reqLevel  = LEVEL_MASK[reqSrcQ];
  assign reqInHigh = srcReq[reqSrcQ];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < EN_BYTES; b++) enByte[b] <= '0;
      for (int e = 0; e < NUM_PTAB; e++) prioTab[e] <= '0;
      for (int n = 0; n < NUM_SRC; n++)  idxMap[n] <= '0;
      fastOn  <= 1'b0;
      fastVec <= '0;
    end else if (cfgWe) begin
      unique case (cfgSel_e'(cfgSel))
        CFG_ENABLE:
          for (int b = 0; b < EN_BYTES; b++)
            if (cfgAddr == 8'(b)) enByte[b] <= cfgData[7:0];
        CFG_PRIO:
          for (int e = 0; e < NUM_PTAB; e++)
            if (cfgAddr == 8'(e)) prioTab[e] <= cfgData[PRIO_W-1:0];
        CFG_MAP:
          for (int n = 0; n < NUM_SRC; n++)
            if (cfgAddr == 8'(n)) idxMap[n] <= cfgData[IDX_W-1:0];
        CFG_FAST: begin
          fastOn  <= cfgData[15];
          fastVec <= cfgData[7:0];
        end
      endcase
    end
  end

  // pending flags and the request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ     <= '0;
      reqValidQ <= 1'b0;
      reqSrcQ   <= '0;
      reqPrioQ  <= '0;
      reqFastQ  <= 1'b0;
    end else begin
      pendQ <= strobe.serve ? pendAfterServe : pendAfterHold;
      if (strobe.loadScan) begin
        reqValidQ <= 1'b1;
        reqSrcQ   <= bestIdx;
        reqPrioQ  <= bestPrio;
        reqFastQ  <= fastOn && (fastVec == SRC_W'(bestIdx));
      end else if (strobe.loadNew) begin
        reqValidQ <= 1'b1;
        reqSrcQ   <= newIdx;
        reqPrioQ  <= srcPrio[newIdx];
        reqFastQ  <= fastOn && (fastVec == SRC_W'(newIdx));
      end else if (strobe.clear) begin
        reqValidQ <= 1'b0;
      end
    end
  end

  assign reqSrcOut  = SRC_W'(reqSrcQ);
  assign reqPrioOut = reqPrioQ;
  assign reqFast    = reqFastQ;
endmodule

// File: rtl/pia_arbiter.sv
module pia_arbiter
  import pia_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PTAB = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 'hF0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               ackIn,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [7:0]         cfgAddr,
  input  logic [15:0]        cfgData,
  output logic               irqValid,
  output logic [11:0]        irqCode,
  output logic               fiqValid,
  output logic [11:0]        fiqCode
);
  ctlStrobe_t        strobe;
  logic              reqValid, reqLevel, reqInHigh, scanHit, newHit, reqFast;
  logic [SRC_W-1:0]  reqSrc;
  logic [PRIO_W-1:0] reqPrio;
  logic [CODE_W-1:0] reqCode;

  pia_control u_ctl (
    .ackIn    (ackIn),
    .reqValid (reqValid),
    .reqLevel (reqLevel),
    .reqInHigh(reqInHigh),
    .scanHit  (scanHit),
    .newHit   (newHit),
    .strobe   (strobe)
  );

  pia_datapath #(.NUM_SRC(NUM_SRC), .NUM_PTAB(NUM_PTAB), .LEVEL_MASK(LEVEL_MASK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcReq    (srcReq),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .strobe    (strobe),
    .reqValid  (reqValid),
    .reqLevel  (reqLevel),
    .reqInHigh (reqInHigh),
    .scanHit   (scanHit),
    .newHit    (newHit),
    .reqSrcOut (reqSrc),
    .reqPrioOut(reqPrio),
    .reqFast   (reqFast)
  );

  assign reqCode  = {reqPrio, reqSrc};
  assign irqValid = reqValid & ~reqFast;
  assign fiqValid = reqValid & reqFast;
  assign irqCode  = irqValid ? reqCode : '0;
  assign fiqCode  = fiqValid ? reqCode : '0;
endmodule

// File: rtl/pia_arbiter_chk.sv
module pia_arbiter_chk #(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               ackIn,
  input logic               irqValid,
  input logic [11:0]        irqCode,
  input logic               fiqValid,
  input logic [11:0]        fiqCode
);
  function automatic logic isLevel(input logic [7:0] s);
    logic r = 1'b0;
    for (int n = 0; n < NUM_SRC; n++) if (s == 8'(n)) r = LEVEL_MASK[n];
    return r;
  endfunction

  function automatic logic inHigh(input logic [NUM_SRC-1:0] v, input logic [7:0] s);
    logic r = 1'b0;
    for (int n = 0; n < NUM_SRC; n++) if (s == 8'(n)) r = v[n];
    return r;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> (!irqValid && !fiqValid));

  a_r6_one_output: assert property (@(posedge clk) disable iff (!rstN)
    !(irqValid && fiqValid));

  a_r6_idle_code_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid |-> irqCode == 12'h000) and (!fiqValid |-> fiqCode == 12'h000));

  a_r3_no_source_zero: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid |-> irqCode[7:0] != 8'h00) and (fiqValid |-> fiqCode[7:0] != 8'h00));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !ackIn && !isLevel(irqCode[7:0])) |=> (irqValid && $stable(irqCode)));

  a_r11_level_drop: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !ackIn && isLevel(irqCode[7:0]) && !inHigh(srcReq, irqCode[7:0]))
      |=> !(irqValid && irqCode == $past(irqCode)));
endmodule

bind pia_arbiter pia_arbiter_chk #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .ackIn(ackIn),
  .irqValid(irqValid), .irqCode(irqCode), .fiqValid(fiqValid), .fiqCode(fiqCode)
);

// File: tb/pia_arbiter_bench.sv
module pia_arbiter_bench;
  localparam int NS = 32;
  localparam int NP = 16;
  localparam logic [NS-1:0] LVL = 32'h0000_00F0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcReq = '0;
  logic          ackIn = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [7:0]    cfgAddr = '0;
  logic [15:0]   cfgData = '0;
  logic          irqValid, fiqValid;
  logic [11:0]   irqCode, fiqCode;

  always #4 clk = ~clk;

  pia_arbiter #(.NUM_SRC(NS), .NUM_PTAB(NP), .LEVEL_MASK(LVL)) u_pia_arbiter (.*);

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;
  string curReq  = "R1";

  // reference state
  logic [NS-1:0] mEn, mPend;
  logic [3:0]    mTab [NP];
  logic [3:0]    mMap [NS];
  logic          mFastOn, mValid, mFast;
  logic [7:0]    mFastVec, mSrc;
  logic [3:0]    mPrio;
  // next state
  logic [NS-1:0] xEn, xPend;
  logic [3:0]    xTab [NP];
  logic [3:0]    xMap [NS];
  logic          xFastOn, xValid, xFast;
  logic [7:0]    xFastVec, xSrc;
  logic [3:0]    xPrio;

  function automatic logic [3:0] prioOf(int n);
    return mTab[mMap[n]];
  endfunction

  task automatic modelReset();
    mEn = '0; mPend = '0; mFastOn = 0; mFastVec = '0;
    mValid = 0; mFast = 0; mSrc = '0; mPrio = '0;
    for (int e = 0; e < NP; e++) mTab[e] = '0;
    for (int n = 0; n < NS; n++) mMap[n] = '0;
  endtask

  task automatic modelNext();
    logic serve, drop, scanHit, newHit;
    logic [NS-1:0] served, pServe, pHold;
    int best, bi, ni;
    xEn = mEn; xTab = mTab; xMap = mMap; xFastOn = mFastOn; xFastVec = mFastVec;
    xValid = mValid; xSrc = mSrc; xPrio = mPrio; xFast = mFast;
    serve  = ackIn && mValid;                                   // R8, R12
    served = (mValid && !LVL[mSrc]) ? (NS'(1) << mSrc) : '0;
    pServe = (LVL & srcReq) | (~LVL & ((mPend & ~served) | srcReq));
    pHold  = (LVL & srcReq) | (~LVL & (mPend | srcReq));
    xPend  = serve ? pServe : pHold;
    best = 0; bi = 0;                                           // R9 ascending strict scan
    for (int n = 0; n < NS; n++)
      if (pServe[n] && int'(prioOf(n)) > best) begin best = int'(prioOf(n)); bi = n; end
    scanHit = (best != 0) && (bi != 0) && mEn[bi];              // R10, R3
    newHit = 0; ni = 0;                                         // R4 lowest enabled arrival
    for (int n = NS - 1; n >= 1; n--)
      if (srcReq[n] && mEn[n]) begin newHit = 1; ni = n; end
    drop = mValid && !serve && LVL[mSrc] && !srcReq[mSrc];      // R11
    if (serve) begin
      xValid = scanHit;
      if (scanHit) begin
        xSrc = 8'(bi); xPrio = prioOf(bi); xFast = mFastOn && (mFastVec == 8'(bi));
      end
    end else if (!mValid || drop) begin
      xValid = newHit;
      if (newHit) begin
        xSrc = 8'(ni); xPrio = prioOf(ni); xFast = mFastOn && (mFastVec == 8'(ni));
      end
    end
    if (cfgWe) begin                                            // R2, R5, R6 writes
      case (cfgSel)
        2'd0: if (cfgAddr < 8'(NS/8)) xEn[cfgAddr*8 +: 8] = cfgData[7:0];
        2'd1: if (cfgAddr < 8'(NP)) xTab[cfgAddr] = cfgData[3:0];
        2'd2: if (cfgAddr < 8'(NS)) xMap[cfgAddr] = cfgData[3:0];
        default: begin xFastOn = cfgData[15]; xFastVec = cfgData[7:0]; end
      endcase
    end
  endtask

  task automatic checkOut();
    logic        eIrqV, eFiqV;
    logic [11:0] eIrqC, eFiqC;
    eIrqV = mValid && !mFast;
    eFiqV = mValid && mFast;
    eIrqC = eIrqV ? {mPrio, mSrc} : 12'h000;
    eFiqC = eFiqV ? {mPrio, mSrc} : 12'h000;
    nChecks++;
    if (irqValid !== eIrqV || irqCode !== eIrqC || fiqValid !== eFiqV || fiqCode !== eFiqC) begin
      nFails++;
      $display("FAIL %s: irq %0b/%h fiq %0b/%h, expected irq %0b/%h fiq %0b/%h",
               curReq, irqValid, irqCode, fiqValid, fiqCode, eIrqV, eIrqC, eFiqV, eFiqC);
    end
  endtask

  task automatic cycle();
    modelNext();
    @(posedge clk);
    mEn = xEn; mPend = xPend; mTab = xTab; mMap = xMap; mFastOn = xFastOn;
    mFastVec = xFastVec; mValid = xValid; mSrc = xSrc; mPrio = xPrio; mFast = xFast;
    @(negedge clk);
    checkOut();
  endtask

  logic [NS-1:0] lvlHold = '0;

  task automatic pulse(logic [NS-1:0] bits, logic ack);
    srcReq = lvlHold | (bits & ~LVL); ackIn = ack;
    cycle();
    srcReq = lvlHold; ackIn = 0;
  endtask

  task automatic cfgWrite(logic [1:0] s, logic [7:0] a, logic [15:0] d);
    cfgWe = 1; cfgSel = s; cfgAddr = a; cfgData = d;
    cycle();
    cfgWe = 0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    curReq = "R1"; checkOut();
    rstN = 1;
    pulse(NS'(1) << 9, 0);  idle(2);                 // R1: nothing enabled yet
    curReq = "R5";
    for (int e = 0; e < NP; e++) cfgWrite(2'd1, 8'(e), 16'(e));
    for (int n = 0; n < NS; n++) cfgWrite(2'd2, 8'(n), 16'(n % NP));
    curReq = "R2";
    cfgWrite(2'd0, 8'd1, 16'h0002);                  // only source 9 enabled
    pulse(NS'(1) << 10, 0); idle(1);                 // disabled: pending only
    pulse(NS'(1) << 9, 0);  idle(1);                 // expect code 9_09
    curReq = "R7";
    cfgWrite(2'd0, 8'd0, 16'h00FF);
    cfgWrite(2'd0, 8'd1, 16'hFFFF);
    pulse((NS'(1) << 12) | (NS'(1) << 13), 0); idle(3);
    curReq = "R9";
    pulse('0, 1); idle(1);                           // 13 has top priority
    cfgWrite(2'd2, 8'd12, 16'd1); cfgWrite(2'd2, 8'd10, 16'd1);
    cfgWrite(2'd1, 8'd1, 16'd6);                      // tie 10 and 12 at prio 6
    pulse('0, 1); idle(1);
    curReq = "R8";
    pulse('0, 1); pulse('0, 1); pulse('0, 1); idle(1);
    curReq = "R12";
    pulse('0, 1); idle(1);
    curReq = "R4";
    pulse((NS'(1) << 14) | (NS'(1) << 11), 0); idle(1); // 11 wins though 14 higher
    curReq = "R10";
    cfgWrite(2'd0, 8'd1, 16'h08);                    // disable 14 (pending), keep 11
    pulse('0, 1); idle(2);
    curReq = "R3";
    cfgWrite(2'd2, 8'd0, 16'd15);
    pulse(NS'(1), 0); idle(1);
    cfgWrite(2'd0, 8'd1, 16'hFF);
    pulse(NS'(1) << 9, 0); pulse('0, 1); idle(1);    // source 0 wins scan, not served
    curReq = "R6";
    cfgWrite(2'd3, 8'd0, 16'h8005);
    lvlHold[5] = 1; srcReq = lvlHold; idle(3);
    curReq = "R11";
    lvlHold[5] = 0; srcReq = lvlHold; idle(2);
    lvlHold[6] = 1; srcReq = lvlHold; idle(2);
    lvlHold[6] = 0; lvlHold[7] = 1; srcReq = lvlHold; idle(2);
    curReq = "R6";
    cfgWrite(2'd3, 8'd0, 16'h0007); pulse('0, 1); idle(2);

    curReq = "R9";
    for (int i = 0; i < 6000; i++) begin
      logic [NS-1:0] pb;
      pb = '0;
      for (int n = 0; n < NS; n++) if ($urandom_range(0, 24) == 0) pb[n] = 1;
      for (int n = 4; n < 8; n++) if ($urandom_range(0, 15) == 0) lvlHold[n] = ~lvlHold[n];
      if ($urandom_range(0, 40) == 0) begin
        cfgWe = 1; cfgSel = 2'($urandom_range(0, 3)); cfgAddr = 8'($urandom_range(0, 33));
        cfgData = 16'($urandom);
        if (cfgSel == 2'd0) cfgData[7:0] = cfgData[7:0] | 8'hE7;
        if (cfgSel == 2'd3) cfgData[7:0] = 8'($urandom_range(0, NS - 1));
      end
      srcReq = lvlHold | (pb & ~LVL);
      ackIn  = ($urandom_range(0, 5) == 0);
      cycle();
      cfgWe = 0;
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule